// File: doc/BRIEF.md
# Guarded RAM Write Path with Test Modes

This block sits between a CPU port (data reads, data writes and instruction fetches) and one RAM region whose words carry check bits (parity or ECC). Each CPU request is examined against the region's write-block and fetch-block settings and against a 2-bit test mode. The block then issues the request to the RAM with separate enables for the data bits and for the check bits. A refused request is not forwarded. It sets a sticky violation flag that keeps the address and the kind of the offending access until software clears it.

The test mode lets diagnostic software corrupt one half of a stored word on purpose. It can write the data bits without touching the check bits, or the check bits without touching the data bits. A fourth mode writes normally but keeps detected memory errors from raising an interrupt. Any test mode other than normal also overrides write blocking.

A start pulse launches an initialization pass. The pass writes every word of the region once, one word per cycle, with zero data and a fill strobe that tells the RAM wrapper to store the check bits matching zero. CPU requests are stalled for the whole pass, and a done status rises when the pass finishes. The check code itself is computed outside this block.

Top module: `pram_guard`

## Requirements
- R1: During and after reset, all RAM enables, the fill strobe, the violation flag, the stall and the done status are 0, and the error-interrupt enable is 1.
- R2: The CPU operation is encoded as 2'b00 read, 2'b01 write, 2'b10 fetch and 2'b11 idle. In test mode 2'b00, an allowed write presented at one clock edge appears on the outputs after that edge with ram_en, ram_data_we and ram_chk_we all 1, and with the request's address and write data.
- R3: Test mode 2'b01 writes set ram_data_we only, and test mode 2'b10 writes set ram_chk_we only.
- R4: Test mode 2'b11 writes set both write enables. err_irq_en is 0 on the cycle after test mode 2'b11 is presented, and 1 after any other mode.
- R5: When wr_block is 1 and the test mode is 2'b00, a write is refused. Neither write enable nor ram_en is set, and a violation of kind 0 (write) is logged.
- R6: When the test mode is non-zero, wr_block has no effect. The write goes through under the R3/R4 enables and no violation is logged.
- R7: When fetch_block is 1, a fetch is refused. ram_en stays 0 and a violation of kind 1 (fetch) is logged. Reads are never refused by either block bit.
- R8: An init_start pulse while idle raises cpu_stall after the next edge. For the next DEPTH edges the outputs show fill writes: ram_fill, ram_data_we and ram_chk_we are 1, ram_wdata is 0, and the address runs 0 to DEPTH-1. init_done is 0 until the edge that presents address DEPTH-1, where init_done rises and cpu_stall falls.
- R9: An init_start that arrives while a pass is running is ignored; the pass ends at its original time.
- R10: CPU requests presented while cpu_stall is 1 are ignored. They produce no RAM access and no violation.
- R11: The violation flag is sticky, and it keeps the address and kind of the first refused access. While viol_clear is 1 the flag drops, unless a refused access arrives in the same cycle: that access is captured as a new violation.
- R12: A reset clears init_done after a completed pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_op | input | 2 | CPU operation: 00 read, 01 write, 10 fetch, 11 idle |
| cpu_addr | input | ADDR_W | Word address within the region |
| cpu_wdata | input | DATA_W | Write data |
| test_mode | input | 2 | 00 normal, 01 data bits only, 10 check bits only, 11 normal without error interrupt |
| wr_block | input | 1 | Block CPU writes to the region |
| fetch_block | input | 1 | Block instruction fetches from the region |
| init_start | input | 1 | Start the initialization pass |
| viol_clear | input | 1 | Clear the violation flag |
| cpu_stall | output | 1 | CPU requests are ignored while 1 |
| ram_en | output | 1 | RAM access enable |
| ram_addr | output | ADDR_W | RAM address |
| ram_wdata | output | DATA_W | RAM write data |
| ram_data_we | output | 1 | Write enable for the data bits |
| ram_chk_we | output | 1 | Write enable for the check bits |
| ram_fill | output | 1 | Initialization write: store the check bits of zero |
| viol_flag | output | 1 | Sticky access-violation flag |
| viol_addr | output | ADDR_W | Address of the captured violation |
| viol_kind | output | 1 | 0 write refused, 1 fetch refused |
| err_irq_en | output | 1 | Memory-error interrupt permitted |
| init_done | output | 1 | Initialization pass has completed |

## Verification
A wrong decision in the access logic shows one edge after the request. The fault appears as a write enable on the wrong half of the word, as a blocked write that reaches the RAM, or as a violation flag that is missing or raised when it should not be. The sticky capture can also go wrong. A later violation overwriting the first address, or a clear that loses a same-cycle hit, stays visible on viol_addr until the next clear, so it is caught on any later cycle. A faulty pass counter shows in the fill address sequence on each cycle of the pass, and in the exact edge where init_done rises and cpu_stall falls. A start that is wrongly honoured during a pass shows as an address restart or a late done.

// File: rtl/pram_pkg.sv
package pram_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_WRITE = 2'b01,
    OP_FETCH = 2'b10,
    OP_NONE  = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    TM_NORMAL    = 2'b00,
    TM_DATA_ONLY = 2'b01,
    TM_CHK_ONLY  = 2'b10,
    TM_QUIET     = 2'b11
  } tmode_e;

  typedef struct packed {
    logic en;
    logic data_we;
    logic chk_we;
    logic refuse;
    logic kind;     // 0 write refused, 1 fetch refused
  } acc_dec_t;

endpackage

// File: rtl/pram_init_seq.sv
module pram_init_seq #(
  parameter int DEPTH  = 64,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              busy,
  output logic [ADDR_W-1:0] addr,
  output logic              done
);

  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      addr <= '0;
      done <= 1'b0;
    end else if (busy) begin
      // start is deliberately ignored while a pass is running
      if (addr == LAST) begin
        busy <= 1'b0;
        addr <= '0;
        done <= 1'b1;
      end else begin
        addr <= addr + 1'b1;
      end
    end else if (start) begin
      busy <= 1'b1;
      addr <= '0;
      done <= 1'b0;
    end
  end

endmodule

// File: rtl/pram_access_ctl.sv
module pram_access_ctl
  import pram_pkg::*;
(
  input  logic     live,        // request may be served (not stalled)
  input  op_e      op,
  input  tmode_e   mode,
  input  logic     wr_block,
  input  logic     fetch_block,
  output acc_dec_t dec
);

  always_comb begin
    dec = '0;
    if (live) begin
      case (op)
        OP_READ: dec.en = 1'b1;
        OP_WRITE: begin
          if (wr_block && (mode == TM_NORMAL)) begin
            dec.refuse = 1'b1;
            dec.kind   = 1'b0;
          end else begin
            dec.en      = 1'b1;
            dec.data_we = (mode != TM_CHK_ONLY);
            dec.chk_we  = (mode != TM_DATA_ONLY);
          end
        end
        OP_FETCH: begin
          if (fetch_block) begin
            dec.refuse = 1'b1;
            dec.kind   = 1'b1;
          end else begin
            dec.en = 1'b1;
          end
        end
        default: dec = '0;
      endcase
    end
  end

endmodule

// File: rtl/pram_viol_log.sv
module pram_viol_log #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hit,
  input  logic              hit_kind,
  input  logic [ADDR_W-1:0] hit_addr,
  input  logic              clear,
  output logic              flag,
  output logic [ADDR_W-1:0] addr,
  output logic              kind
);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
      addr <= '0;
      kind <= 1'b0;
    end else if (hit && (!flag || clear)) begin
      flag <= 1'b1;
      addr <= hit_addr;
      kind <= hit_kind;
    end else if (clear) begin
      flag <= 1'b0;
    end
  end

endmodule

// File: rtl/pram_guard.sv
module pram_guard
  import pram_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 32,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cpu_op,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic [1:0]        test_mode,
  input  logic              wr_block,
  input  logic              fetch_block,
  input  logic              init_start,
  input  logic              viol_clear,
  output logic              cpu_stall,
  output logic              ram_en,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  output logic              ram_data_we,
  output logic              ram_chk_we,
  output logic              ram_fill,
  output logic              viol_flag,
  output logic [ADDR_W-1:0] viol_addr,
  output logic              viol_kind,
  output logic              err_irq_en,
  output logic              init_done
);

  logic              init_busy;
  logic [ADDR_W-1:0] init_addr;
  acc_dec_t          dec;

  pram_init_seq #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_init (
    .clk   (clk),
    .rst   (rst),
    .start (init_start),
    .busy  (init_busy),
    .addr  (init_addr),
    .done  (init_done)
  );

  pram_access_ctl u_ctl (
    .live        (!init_busy),
    .op          (op_e'(cpu_op)),
    .mode        (tmode_e'(test_mode)),
    .wr_block    (wr_block),
    .fetch_block (fetch_block),
    .dec         (dec)
  );

  pram_viol_log #(.ADDR_W(ADDR_W)) u_viol (
    .clk      (clk),
    .rst      (rst),
    .hit      (dec.refuse),
    .hit_kind (dec.kind),
    .hit_addr (cpu_addr),
    .clear    (viol_clear),
    .flag     (viol_flag),
    .addr     (viol_addr),
    .kind     (viol_kind)
  );

  assign cpu_stall = init_busy;

  // registered RAM request stage
  always_ff @(posedge clk) begin
    if (rst) begin
      ram_en      <= 1'b0;
      ram_addr    <= '0;
      ram_wdata   <= '0;
      ram_data_we <= 1'b0;
      ram_chk_we  <= 1'b0;
      ram_fill    <= 1'b0;
      err_irq_en  <= 1'b1;
    end else begin
      err_irq_en <= (tmode_e'(test_mode) != TM_QUIET);
      if (init_busy) begin
        ram_en      <= 1'b1;
        ram_addr    <= init_addr;
        ram_wdata   <= '0;
        ram_data_we <= 1'b1;
        ram_chk_we  <= 1'b1;
        ram_fill    <= 1'b1;
      end else begin
        ram_en      <= dec.en;
        ram_addr    <= cpu_addr;
        ram_wdata   <= cpu_wdata;
        ram_data_we <= dec.data_we;
        ram_chk_we  <= dec.chk_we;
        ram_fill    <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/pram_guard_chk.sv
module pram_guard_chk #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 32,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        cpu_op,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic [1:0]        test_mode,
  input logic              wr_block,
  input logic              fetch_block,
  input logic              viol_clear,
  input logic              cpu_stall,
  input logic              ram_en,
  input logic [ADDR_W-1:0] ram_addr,
  input logic              ram_data_we,
  input logic              ram_chk_we,
  input logic              ram_fill,
  input logic              viol_flag,
  input logic [ADDR_W-1:0] viol_addr,
  input logic              err_irq_en,
  input logic              init_done
);

  a_r3_data_only: assert property (@(posedge clk) disable iff (rst)
    (!cpu_stall && cpu_op == 2'b01 && test_mode == 2'b01) |=> (ram_data_we && !ram_chk_we));

  a_r4_quiet_irq: assert property (@(posedge clk) disable iff (rst)
    (test_mode == 2'b11) |=> !err_irq_en);

  a_r5_block_refuse: assert property (@(posedge clk) disable iff (rst)
    (!cpu_stall && cpu_op == 2'b01 && wr_block && test_mode == 2'b00)
      |=> (viol_flag && !ram_en && !ram_data_we && !ram_chk_we));

  a_r6_override: assert property (@(posedge clk) disable iff (rst)
    (!cpu_stall && cpu_op == 2'b01 && test_mode != 2'b00) |=> (ram_en && (ram_data_we || ram_chk_we)));

  a_r7_fetch_refuse: assert property (@(posedge clk) disable iff (rst)
    (!cpu_stall && cpu_op == 2'b10 && fetch_block) |=> (viol_flag && !ram_en));

  a_r8_first_fill: assert property (@(posedge clk) disable iff (rst)
    $rose(cpu_stall) |=> (ram_fill && ram_addr == '0));

  a_r8_done_at_end: assert property (@(posedge clk) disable iff (rst)
    $fell(cpu_stall) |-> (init_done && ram_fill));

  a_r10_stall_fill: assert property (@(posedge clk) disable iff (rst)
    cpu_stall |=> ram_fill);

  a_r11_sticky: assert property (@(posedge clk) disable iff (rst)
    (viol_flag && !viol_clear) |=> (viol_flag && $stable(viol_addr)));

endmodule

bind pram_guard pram_guard_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cpu_op      (cpu_op),
  .cpu_addr    (cpu_addr),
  .test_mode   (test_mode),
  .wr_block    (wr_block),
  .fetch_block (fetch_block),
  .viol_clear  (viol_clear),
  .cpu_stall   (cpu_stall),
  .ram_en      (ram_en),
  .ram_addr    (ram_addr),
  .ram_data_we (ram_data_we),
  .ram_chk_we  (ram_chk_we),
  .ram_fill    (ram_fill),
  .viol_flag   (viol_flag),
  .viol_addr   (viol_addr),
  .err_irq_en  (err_irq_en),
  .init_done   (init_done)
);

// File: tb/tb_pram_guard.sv
`timescale 1ns/1ps
module tb_pram_guard;

  localparam int DEPTH  = 64;
  localparam int DATA_W = 32;
  localparam int ADDR_W = $clog2(DEPTH);

  logic              clk = 1'b0;
  logic              rst;
  logic [1:0]        cpu_op;
  logic [ADDR_W-1:0] cpu_addr;
  logic [DATA_W-1:0] cpu_wdata;
  logic [1:0]        test_mode;
  logic              wr_block, fetch_block, init_start, viol_clear;
  logic              cpu_stall, ram_en, ram_data_we, ram_chk_we, ram_fill;
  logic [ADDR_W-1:0] ram_addr, viol_addr;
  logic [DATA_W-1:0] ram_wdata;
  logic              viol_flag, viol_kind, err_irq_en, init_done;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  // model of the sticky violation log
  logic              m_flag;
  logic [ADDR_W-1:0] m_addr;
  logic              m_kind;

  always #2 clk = ~clk;

  pram_guard #(.DEPTH(DEPTH), .DATA_W(DATA_W)) dut (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic drive(input logic [1:0] op, input logic [ADDR_W-1:0] a,
                       input logic [DATA_W-1:0] d, input logic [1:0] m,
                       input logic wb, input logic fb, input logic clr);
    cpu_op = op; cpu_addr = a; cpu_wdata = d; test_mode = m;
    wr_block = wb; fetch_block = fb; viol_clear = clr;
  endtask

  task automatic idle();
    drive(2'b11, '0, '0, 2'b00, 1'b0, 1'b0, 1'b0);
    init_start = 1'b0;
  endtask

  // expected {en, data_we, chk_we, refuse, kind}
  function automatic logic [4:0] exp_dec(input logic [1:0] op, input logic [1:0] m,
                                         input logic wb, input logic fb);
    case (op)
      2'b00: return 5'b10000;
      2'b01: if (wb && m == 2'b00) return 5'b00010;
             else return {1'b1, m != 2'b10, m != 2'b01, 2'b00};
      2'b10: return fb ? 5'b00011 : 5'b10000;
      default: return 5'b00000;
    endcase
  endfunction

  task automatic model_viol(input logic hit, input logic k, input logic [ADDR_W-1:0] a,
                            input logic clr);
    if (hit && (!m_flag || clr)) begin
      m_flag = 1'b1; m_addr = a; m_kind = k;
    end else if (clr) begin
      m_flag = 1'b0;
    end
  endtask

  // apply one request with current inputs, step, check outputs against model
  task automatic access_check(input string req);
    logic [4:0] e;
    logic [1:0] op_s;
    logic [1:0] m_s;
    logic [ADDR_W-1:0] a_s;
    logic [DATA_W-1:0] d_s;
    e = exp_dec(cpu_op, test_mode, wr_block, fetch_block);
    op_s = cpu_op; m_s = test_mode; a_s = cpu_addr; d_s = cpu_wdata;
    model_viol(e[1], e[0], cpu_addr, viol_clear);
    step();
    check({ram_en, ram_data_we, ram_chk_we} == e[4:2], req, "enables",
          {ram_en, ram_data_we, ram_chk_we}, e[4:2]);
    if (e[4])
      check(ram_addr == a_s, req, "ram_addr", ram_addr, a_s);
    if (e[3] || e[2])
      check(ram_wdata == d_s, req, "ram_wdata", ram_wdata, d_s);
    check(viol_flag == m_flag, req, "viol_flag", viol_flag, m_flag);
    if (m_flag)
      check({viol_addr, viol_kind} == {m_addr, m_kind}, req, "viol addr/kind",
            {viol_addr, viol_kind}, {m_addr, m_kind});
    check(err_irq_en == (m_s != 2'b11), "R4", "err_irq_en", err_irq_en, m_s != 2'b11);
    check(ram_fill == 1'b0, req, "ram_fill", ram_fill, 0);
    if (op_s == 2'b11) check(!ram_en, req, "idle en", ram_en, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_flag = 0; m_addr = '0; m_kind = 0;
    rst = 1'b1;
    idle();
    viol_clear = 1'b0;
    repeat (3) step();
    // R1 reset state
    check({ram_en, ram_data_we, ram_chk_we, ram_fill, viol_flag, cpu_stall, init_done} == 7'b0,
          "R1", "reset outputs", {ram_en, ram_data_we, ram_chk_we, ram_fill, viol_flag, cpu_stall, init_done}, 0);
    check(err_irq_en == 1'b1, "R1", "reset err_irq_en", err_irq_en, 1);
    rst = 1'b0;
    step();

    // R2 normal write
    drive(2'b01, 6'd17, 32'hCAFE_0017, 2'b00, 1'b0, 1'b0, 1'b0);
    access_check("R2");
    // R3 data-only and check-only
    drive(2'b01, 6'd3, 32'h1111_2222, 2'b01, 1'b0, 1'b0, 1'b0);
    access_check("R3");
    drive(2'b01, 6'd4, 32'h3333_4444, 2'b10, 1'b0, 1'b0, 1'b0);
    access_check("R3");
    // R4 quiet mode write
    drive(2'b01, 6'd5, 32'h5555_6666, 2'b11, 1'b0, 1'b0, 1'b0);
    access_check("R4");
    // R6 override with wr_block in modes 01, 10 and 11
    drive(2'b01, 6'd6, 32'h0000_00A6, 2'b11, 1'b1, 1'b0, 1'b0);
    access_check("R6");
    drive(2'b01, 6'd7, 32'h0000_00A7, 2'b01, 1'b1, 1'b0, 1'b0);
    access_check("R6");
    drive(2'b01, 6'd8, 32'h0000_00A8, 2'b10, 1'b1, 1'b0, 1'b0);
    access_check("R6");
    check(viol_flag == 1'b0, "R6", "no violation", viol_flag, 0);
    // R7 read unaffected by blocks
    drive(2'b00, 6'd9, '0, 2'b00, 1'b1, 1'b1, 1'b0);
    access_check("R7");
    // R5 blocked write, R11 sticky first address
    drive(2'b01, 6'd21, 32'hDEAD_0021, 2'b00, 1'b1, 1'b0, 1'b0);
    access_check("R5");
    drive(2'b10, 6'd40, '0, 2'b00, 1'b0, 1'b1, 1'b0);
    access_check("R11");
    check(viol_addr == 6'd21 && viol_kind == 1'b0, "R11", "first kept",
          {viol_addr, viol_kind}, {6'd21, 1'b0});
    // R11 clear with simultaneous hit captures the new one, R7 fetch refused
    drive(2'b10, 6'd42, '0, 2'b01, 1'b0, 1'b1, 1'b1);
    access_check("R7");
    check(viol_addr == 6'd42 && viol_kind == 1'b1, "R11", "clear+hit",
          {viol_addr, viol_kind}, {6'd42, 1'b1});
    drive(2'b11, '0, '0, 2'b00, 1'b0, 1'b0, 1'b1);
    access_check("R11");

    // random mix
    for (int i = 0; i < 400; i++) begin
      drive(2'($urandom_range(3, 0)), ADDR_W'($urandom), $urandom, 2'($urandom_range(3, 0)),
            ($urandom_range(2, 0) == 0), ($urandom_range(2, 0) == 0), ($urandom_range(7, 0) == 0));
      access_check("R2/R3/R5/R6/R7/R11");
    end

    // R8 initialization pass
    idle();
    drive(2'b11, '0, '0, 2'b00, 1'b0, 1'b0, 1'b1);
    model_viol(1'b0, 1'b0, '0, 1'b1);
    step();
    viol_clear = 1'b0;
    init_start = 1'b1;
    step();
    init_start = 1'b0;
    check(cpu_stall == 1'b1, "R8", "stall after start", cpu_stall, 1);
    check(init_done == 1'b0, "R8", "done low at start", init_done, 0);
    for (int k = 1; k <= DEPTH; k++) begin
      // R10: blocked write offered during the pass; R9: second start mid-pass
      drive(2'b01, 6'd33, 32'hFFFF_FFFF, 2'b00, 1'b1, 1'b0, 1'b0);
      init_start = (k == 5);
      step();
      check(ram_fill && ram_en && ram_data_we && ram_chk_we && ram_wdata == '0 &&
            ram_addr == ADDR_W'(k - 1), "R8", "fill write",
            {ram_fill, ram_addr, ram_wdata}, {1'b1, ADDR_W'(k - 1), 32'h0});
      check(init_done == (k == DEPTH), "R9", "done timing", init_done, k == DEPTH);
      check(cpu_stall == (k != DEPTH), "R8", "stall timing", cpu_stall, k != DEPTH);
    end
    idle();
    check(viol_flag == 1'b0, "R10", "stalled request ignored", viol_flag, 0);
    step();
    check(ram_fill == 1'b0 && cpu_stall == 1'b0, "R9", "pass ended once",
          {ram_fill, cpu_stall}, 0);

    // R12 reset clears done
    rst = 1'b1;
    step();
    rst = 1'b0;
    check(init_done == 1'b0, "R12", "done after reset", init_done, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule